// File: doc/BRIEF.md
# Overclock Watchdog with Frequency Recovery

This block protects a system that is being overclocked. Software arms a countdown whose length is a chosen multiple (1 to 7) of one of two base periods, or a short test length. If the countdown runs out before software intervenes, the block drives an active-low system reset pulse of fixed width and raises a sticky alarm flag. Depending on a mode bit, it also hands a 9-bit frequency word back to the clock synthesizer, with a one-cycle load strobe, so that the machine reboots at a safe setting.

The recovered word comes from one of four places: the value latched from hardware straps, a recovery register written by software, the same register filled automatically with the running word when the watchdog is armed, or nowhere at all (reset pulse only). The same pulse generator also serves a software reset request. The request bit clears itself once the pulse has ended. A request that arrives while a pulse is running, or in the cycle a timeout fires, shares that one pulse.

All timing advances on a tick-enable input, so base periods and the pulse width are parameters counted in ticks. After a timeout the watchdog stays idle until its settings change or it is disabled and enabled again.

Top module: `oc_watchdog`

## Requirements
- R1: Timer codes 1 to 7 on `wd_mult` give a countdown of code times the base period in ticks. Code 0 is a test mode of `TEST_TICKS` ticks. The timeout fires on the last tick of the countdown.
- R2: `wd_long` = 0 selects a base period of `SHORT_TICKS` and `wd_long` = 1 selects `LONG_TICKS`.
- R3: A rising edge of `wd_en` loads the countdown and starts it. Dropping `wd_en` stops it, so no pulse and no alarm follow.
- R4: On timeout, `sreset_n` goes low for exactly `PULSE_TICKS` ticks, and it only returns high on a tick. `alarm` is set on the same clock edge and stays set until an `alarm_clr` strobe.
- R5: A change of `wd_mult` or `wd_long` while `wd_en` is high restarts the countdown from the new length.
- R6: After a timeout the watchdog produces no further pulse, however many ticks pass, until R3 or R5 re-arms it.
- R7: With `reset_only` = 1 a timeout gives no `n_load`. With `reset_only` = 0, `n_load` is high for one cycle after the timeout edge and `n_out` holds the recovered word.
- R8: The recovered word is `hw_n` when `rec_from_reg` = 0, and the recovery register when `rec_from_reg` = 1.
- R9: With `auto_rec` = 1, the recovery register captures `cur_n` on the rising edge of `wd_en`, and `rec_wr` is ignored. With `auto_rec` = 0, `rec_wr` loads `rec_wdata`.
- R10: A one-cycle `sw_rst_set` strobe raises `sw_pend` on the next edge. When idle, the pulse starts one edge later, lasts `PULSE_TICKS` ticks, and `sw_pend` drops on the edge where `sreset_n` returns high. `alarm` is not affected.
- R11: A software request and a timeout that coincide produce a single pulse of `PULSE_TICKS` ticks, not two.
- R12: After reset, `sreset_n` = 1, `alarm` = 0, `n_load` = 0, `n_out` = 0 and `sw_pend` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; all countdowns advance on it |
| wd_en | input | 1 | Watchdog enable; a rising edge arms it |
| wd_mult | input | 3 | Timer multiple, 0 = test length |
| wd_long | input | 1 | Base period select, 1 = long |
| reset_only | input | 1 | 1 = timeout only pulses reset |
| rec_from_reg | input | 1 | Recovery source, 1 = recovery register |
| auto_rec | input | 1 | 1 = capture running word on arm |
| rec_wr | input | 1 | Write strobe for the recovery register |
| rec_wdata | input | NW | Recovery register write data |
| cur_n | input | NW | Frequency word currently in use |
| hw_n | input | NW | Frequency word latched from straps |
| alarm_clr | input | 1 | Strobe clearing the alarm flag |
| sw_rst_set | input | 1 | Strobe requesting a software reset |
| sreset_n | output | 1 | Active-low reset pulse |
| alarm | output | 1 | Sticky timeout flag |
| n_out | output | NW | Recovered frequency word |
| n_load | output | 1 | One-cycle strobe for `n_out` |
| sw_pend | output | 1 | Software reset request bit, self-clearing |

## Verification
The properties assume that `alarm_clr`, `sw_rst_set` and `rec_wr` are single-cycle strobes, and that `tick` is a plain enable sampled at the clock edge, with no relation to it assumed. The width property counts ticks while `sreset_n` is low, so it relies on every pulse starting from the idle level. The absorbing pulse generator keeps that true even when requests overlap. The stimulus changes inputs only between clock edges, raises `tick` for one cycle in every two, and holds the configuration steady except where a restart or a merge is the thing under test.

// File: rtl/oc_watchdog.sv
module oc_watchdog #(
  parameter int NW          = 9,
  parameter int SHORT_TICKS = 3,
  parameter int LONG_TICKS  = 5,
  parameter int TEST_TICKS  = 2,
  parameter int PULSE_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wd_en,
  input  logic [2:0]    wd_mult,
  input  logic          wd_long,
  input  logic          reset_only,
  input  logic          rec_from_reg,
  input  logic          auto_rec,
  input  logic          rec_wr,
  input  logic [NW-1:0] rec_wdata,
  input  logic [NW-1:0] cur_n,
  input  logic [NW-1:0] hw_n,
  input  logic          alarm_clr,
  input  logic          sw_rst_set,
  output logic          sreset_n,
  output logic          alarm,
  output logic [NW-1:0] n_out,
  output logic          n_load,
  output logic          sw_pend
);
  localparam int MAXB = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int MAXL = (7 * MAXB > TEST_TICKS) ? 7 * MAXB : TEST_TICKS;
  localparam int CW   = $clog2(MAXL + 1);
  localparam int PW   = $clog2(PULSE_TICKS + 1);

  logic          en_q, long_q, armed;
  logic [2:0]    mult_q;
  logic [CW-1:0] cnt, base_c, load_val;
  logic [PW-1:0] pcnt;
  logic [NW-1:0] rec_q;
  logic          en_rise, cfg_chg, rearm, fire, pact, pulse_end, start;

  assign en_rise   = wd_en & ~en_q;
  assign cfg_chg   = (wd_mult != mult_q) | (wd_long != long_q);
  assign rearm     = wd_en & (en_rise | cfg_chg);
  assign base_c    = wd_long ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);
  assign load_val  = (wd_mult == 3'd0) ? CW'(TEST_TICKS) : CW'(wd_mult) * base_c;
  assign fire      = armed & wd_en & tick & ~rearm & (cnt == CW'(1));

  assign pact      = (pcnt != '0);
  assign pulse_end = pact & tick & (pcnt == PW'(1));
  assign start     = ~pact & (fire | sw_pend);
  assign sreset_n  = ~pact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mult_q <= 3'd0;
      long_q <= 1'b1;
    end else begin
      en_q   <= wd_en;
      mult_q <= wd_mult;
      long_q <= wd_long;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!wd_en) begin
      armed <= 1'b0;
    end else if (rearm) begin
      armed <= 1'b1;
      cnt   <= load_val;
    end else if (armed && tick) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pcnt <= '0;
    else if (start)     pcnt <= PW'(PULSE_TICKS);
    else if (pact && tick) pcnt <= pcnt - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sw_pend <= 1'b0;
    else if (sw_rst_set) sw_pend <= 1'b1;
    else if (pulse_end)  sw_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm <= 1'b0;
    else if (fire)      alarm <= 1'b1;
    else if (alarm_clr) alarm <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rec_q <= '0;
    else if (auto_rec && en_rise) rec_q <= cur_n;
    else if (!auto_rec && rec_wr) rec_q <= rec_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_load <= 1'b0;
      n_out  <= '0;
    end else begin
      n_load <= fire & ~reset_only;
      if (fire && !reset_only) n_out <= rec_from_reg ? rec_q : hw_n;
    end
  end
endmodule

module oc_watchdog_chk #(
  parameter int PULSE_TICKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic reset_only,
  input logic sreset_n,
  input logic alarm,
  input logic n_load,
  input logic sw_pend
);
  int lowtk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowtk <= 0;
    else if (sreset_n) lowtk <= 0;
    else if (tick)     lowtk <= lowtk + 1;
  end

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lowtk <= PULSE_TICKS);

  assert_pulse_holds_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sreset_n && !tick) |=> !sreset_n);

  assert_alarm_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (!sreset_n || $past(!sreset_n)));

  assert_load_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    n_load |=> !n_load);

  assert_load_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    n_load |-> $past(!reset_only));

  assert_sw_clear_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_pend) |-> (sreset_n && $past(!sreset_n)));
endmodule

bind oc_watchdog oc_watchdog_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reset_only(reset_only),
  .sreset_n(sreset_n), .alarm(alarm), .n_load(n_load), .sw_pend(sw_pend)
);

// File: tb/tb_oc_watchdog.sv
`timescale 1ns/1ps
module tb_oc_watchdog;
  localparam int NW = 9, SH = 3, LG = 5, TT = 2, PT = 4;

  logic clk = 0, rst_n = 0, tick = 0, wd_en = 0, wd_long = 1;
  logic [2:0] wd_mult = 0;
  logic reset_only = 0, rec_from_reg = 0, auto_rec = 0, rec_wr = 0;
  logic [NW-1:0] rec_wdata = 0, cur_n = 0, hw_n = 0;
  logic alarm_clr = 0, sw_rst_set = 0;
  logic sreset_n, alarm, n_load, sw_pend;
  logic [NW-1:0] n_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oc_watchdog #(.NW(NW), .SHORT_TICKS(SH), .LONG_TICKS(LG), .TEST_TICKS(TT),
                .PULSE_TICKS(PT)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_en(wd_en), .wd_mult(wd_mult),
    .wd_long(wd_long), .reset_only(reset_only), .rec_from_reg(rec_from_reg),
    .auto_rec(auto_rec), .rec_wr(rec_wr), .rec_wdata(rec_wdata), .cur_n(cur_n),
    .hw_n(hw_n), .alarm_clr(alarm_clr), .sw_rst_set(sw_rst_set),
    .sreset_n(sreset_n), .alarm(alarm), .n_out(n_out), .n_load(n_load),
    .sw_pend(sw_pend));

  typedef struct packed {
    logic [2:0] mult; logic lng; logic ronly; logic rsel; logic am;
    logic [8:0] hw; logic [8:0] cur; logic [8:0] wr;
    logic [7:0] ticks; logic ld; logic [8:0] n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{mult:3'd1, lng:1'b0, ronly:1'b0, rsel:1'b0, am:1'b0, hw:9'h1A5, cur:9'h000, wr:9'h000, ticks:8'd3,  ld:1'b1, n:9'h1A5},
    '{mult:3'd3, lng:1'b1, ronly:1'b1, rsel:1'b0, am:1'b0, hw:9'h0C3, cur:9'h000, wr:9'h000, ticks:8'd15, ld:1'b0, n:9'h000},
    '{mult:3'd0, lng:1'b0, ronly:1'b0, rsel:1'b1, am:1'b0, hw:9'h001, cur:9'h000, wr:9'h0F3, ticks:8'd2,  ld:1'b1, n:9'h0F3},
    '{mult:3'd7, lng:1'b1, ronly:1'b0, rsel:1'b1, am:1'b1, hw:9'h001, cur:9'h133, wr:9'h000, ticks:8'd35, ld:1'b1, n:9'h133},
    '{mult:3'd2, lng:1'b0, ronly:1'b0, rsel:1'b1, am:1'b1, hw:9'h001, cur:9'h0AA, wr:9'h055, ticks:8'd6,  ld:1'b1, n:9'h0AA},
    '{mult:3'd5, lng:1'b0, ronly:1'b0, rsel:1'b1, am:1'b0, hw:9'h002, cur:9'h000, wr:9'h1FF, ticks:8'd15, ld:1'b1, n:9'h1FF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic ticks_to_low(output int n);
    n = 0;
    while (sreset_n && n < 200) begin step_tick(); n++; end
  endtask

  task automatic ticks_to_high(output int n);
    n = 0;
    while (!sreset_n && n < 200) begin step_tick(); n++; end
  endtask

  task automatic quiet_ticks(input int k, output bit saw_low);
    saw_low = 0;
    for (int i = 0; i < k; i++) begin step_tick(); if (!sreset_n) saw_low = 1; end
  endtask

  task automatic clear_alarm();
    @(negedge clk) alarm_clr = 1;
    @(negedge clk) alarm_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit lowseen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sreset_n === 1'b1, "R12 sreset_n", sreset_n, 1);
    chk(alarm === 1'b0,    "R12 alarm", alarm, 0);
    chk(n_load === 1'b0,   "R12 n_load", n_load, 0);
    chk(n_out === '0,      "R12 n_out", n_out, 0);
    chk(sw_pend === 1'b0,  "R12 sw_pend", sw_pend, 0);

    for (int v = 0; v < 6; v++) begin
      wd_en = 0;
      clear_alarm();
      chk(alarm === 1'b0, "R4 alarm cleared", alarm, 0);
      wd_mult = VEC[v].mult; wd_long = VEC[v].lng; reset_only = VEC[v].ronly;
      rec_from_reg = VEC[v].rsel; auto_rec = VEC[v].am; hw_n = VEC[v].hw;
      cur_n = VEC[v].cur;
      @(negedge clk) wd_en = 1;
      @(negedge clk) begin cur_n = 9'h011; rec_wr = 1; rec_wdata = VEC[v].wr; end
      @(negedge clk) rec_wr = 0;
      ticks_to_low(n);
      chk(n == int'(VEC[v].ticks), "R1 R2 R3 timeout ticks", n, VEC[v].ticks);
      chk(alarm === 1'b1, "R4 alarm set", alarm, 1);
      chk(n_load === VEC[v].ld, "R7 load strobe", n_load, VEC[v].ld);
      if (VEC[v].ld)
        chk(n_out === VEC[v].n, "R8 R9 recovered word", n_out, VEC[v].n);
      ticks_to_high(n);
      chk(n == PT, "R4 pulse width", n, PT);
    end

    quiet_ticks(60, lowseen);
    chk(!lowseen, "R6 dormant after timeout", lowseen, 0);
    @(negedge clk) begin wd_mult = 3'd1; wd_long = 1'b0; end
    @(negedge clk);
    ticks_to_low(n);
    chk(n == 3, "R5 R6 rearm by new code", n, 3);
    ticks_to_high(n);

    wd_en = 0;
    clear_alarm();
    wd_mult = 3'd2; wd_long = 1'b0;
    @(negedge clk) wd_en = 1;
    @(negedge clk);
    quiet_ticks(4, lowseen);
    chk(!lowseen, "R5 no early fire", lowseen, 0);
    @(negedge clk) wd_long = 1'b1;
    @(negedge clk);
    ticks_to_low(n);
    chk(n == 10, "R5 R2 restart on scale change", n, 10);
    ticks_to_high(n);

    wd_en = 0;
    clear_alarm();
    wd_mult = 3'd1; wd_long = 1'b0;
    @(negedge clk) wd_en = 1;
    @(negedge clk);
    quiet_ticks(2, lowseen);
    @(negedge clk) wd_en = 0;
    quiet_ticks(20, lowseen);
    chk(!lowseen, "R3 disable stops count", lowseen, 0);
    chk(alarm === 1'b0, "R3 no alarm after disable", alarm, 0);

    @(negedge clk) sw_rst_set = 1;
    @(negedge clk) sw_rst_set = 0;
    chk(sw_pend === 1'b1, "R10 request bit set", sw_pend, 1);
    chk(sreset_n === 1'b1, "R10 pulse not yet", sreset_n, 1);
    @(negedge clk);
    chk(sreset_n === 1'b0, "R10 pulse started", sreset_n, 0);
    repeat (5) @(negedge clk);
    chk(sreset_n === 1'b0, "R10 holds without tick", sreset_n, 0);
    ticks_to_high(n);
    chk(n == PT, "R10 pulse width", n, PT);
    chk(sw_pend === 1'b0, "R10 self clear", sw_pend, 0);
    chk(alarm === 1'b0, "R10 alarm untouched", alarm, 0);

    wd_mult = 3'd1; wd_long = 1'b0;
    @(negedge clk) wd_en = 1;
    @(negedge clk);
    step_tick(); step_tick();
    sw_rst_set = 1;
    @(negedge clk) begin sw_rst_set = 0; tick = 1; end
    @(negedge clk) tick = 0;
    chk(sreset_n === 1'b0, "R11 merged pulse start", sreset_n, 0);
    chk(alarm === 1'b1, "R11 alarm on merge", alarm, 1);
    ticks_to_high(n);
    chk(n == PT, "R11 merged width", n, PT);
    chk(sw_pend === 1'b0, "R11 request cleared", sw_pend, 0);
    quiet_ticks(3 * PT, lowseen);
    chk(!lowseen, "R11 no second pulse", lowseen, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule